// File: doc/BRIEF.md
# Indexed UART Control Register Front End

This block is the register file front end of one 16550-style UART channel. The host sees only eight byte-wide locations, selected by a 3-bit address with separate read and write strobes. A larger hidden bank of indexed control registers sits behind those locations, together with a few read-only status bytes. Software reaches the bank indirectly: it first writes an offset into the scratchpad location, then reads or writes the index port. The channel's other units use the line control value and the indexed control bytes, which are brought out flat.

The line control location is always reachable. While the last value written there is the enhanced-mode key 0xBF, every other address selects a separate enhanced register bank, and the scratchpad and index port cannot be reached. Two bits in indexed byte 0 gate what the index port returns on a read. Bit 6 turns on read-back of the indexed bytes. Bit 7 exposes the status bytes.

Top module: `uart_idx_regs`

## Requirements
- R1: After reset, the line control value, the scratchpad, every indexed byte, every enhanced byte and the read data output are all 0x00, so indexed access is available from reset.
- R2: Address 3 always selects the line control register in both modes. A write there stores the data, and a read returns the stored value.
- R3: A read strobe loads the selected value into the read data output at the same clock edge, so it is visible one cycle after the strobe. When the line control value is not 0xBF, address 7 is the scratchpad, which can be written and read back.
- R4: When the line control value is not 0xBF, a write to the index port (address 5) stores the data into indexed byte N, where N is the scratchpad value, if N is 0x00 to 0x0F. Byte N appears on icr_o bits [8N+7:8N].
- R5: A write to the index port with a scratchpad offset of 0x10 or more changes no indexed byte.
- R6: While bit 6 of indexed byte 0 is clear, a read of the index port returns the scratchpad value, unless R8 selects a status byte.
- R7: While bit 6 of indexed byte 0 is set, a read of the index port returns indexed byte N for offsets 0x00 to 0x0F. It returns 0x00 for larger offsets, unless R8 selects a status byte.
- R8: While bit 7 of indexed byte 0 is set, a read of the index port at offset 0x10+k (k = 0 to 3) returns status byte k, which is stat_i bits [8k+7:8k]. This holds whatever the state of bit 6. The status bytes are read-only, and writes at those offsets are ignored. While bit 7 is clear, those offsets behave as in R6 and R7.
- R9: While the line control value is 0xBF, every address other than 3 selects its own enhanced byte, which is written and read back at that address. Neither the scratchpad nor any indexed byte changes in this mode. The enhanced bytes cannot be seen in normal mode.
- R10: When the line control value is not 0xBF, addresses 0, 1, 2, 4 and 6 read as 0x00, and writes to them change no register.
- R11: Without a read strobe, the read data output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| stat_i | input | 32 | Four read-only status bytes, byte k at bits [8k+7:8k] |
| rdata_o | output | 8 | Read data, registered on the read strobe |
| lcr_o | output | 8 | Current line control value |
| icr_o | output | 128 | Sixteen indexed control bytes, byte N at bits [8N+7:8N] |

## Verification
The status bytes are the hardest to reach from the ports. Getting to them takes a fixed chain of steps. LCR must be away from 0xBF. The scratchpad must be set to 0x00 and bit 7 written through the index port. The scratchpad must then be moved into the 0x10 to 0x13 window before reading. The random stimulus biases scratchpad writes toward small offsets and the status window, and weights LCR writes away from the key, so the chain happens repeatedly. Directed cases first pin down the priority of status over read-enable, the ignored writes at status offsets, and the isolation of the enhanced bank.

// File: rtl/uart_idx_pkg.sv
package uart_idx_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LCR,
        SEL_SPR,
        SEL_IDX,
        SEL_ENH
    } reg_sel_e;

endpackage

// File: rtl/uart_idx_decode.sv
module uart_idx_decode
    import uart_idx_pkg::*;
#(
    parameter int              AW    = 3,
    parameter int              DW    = 8,
    parameter logic [AW-1:0]   A_LCR = 3'd3,
    parameter logic [AW-1:0]   A_IDX = 3'd5,
    parameter logic [AW-1:0]   A_SPR = 3'd7,
    parameter logic [DW-1:0]   KEY   = 8'hBF
) (
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] lcr_i,
    output reg_sel_e      sel_o
);

    always_comb begin
        if (addr_i == A_LCR) begin
            sel_o = SEL_LCR;
        end else if (lcr_i == KEY) begin
            sel_o = SEL_ENH;
        end else if (addr_i == A_SPR) begin
            sel_o = SEL_SPR;
        end else if (addr_i == A_IDX) begin
            sel_o = SEL_IDX;
        end else begin
            sel_o = SEL_NONE;
        end
    end

endmodule

// File: rtl/uart_idx_bank.sv
module uart_idx_bank #(
    parameter int DW       = 8,
    parameter int NUM_ICR  = 16,
    parameter int NUM_ASR  = 4,
    parameter int ASR_BASE = 16,
    parameter int RD_BIT   = 6,
    parameter int ST_BIT   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [DW-1:0]          off_i,
    input  logic [DW-1:0]          wdata_i,
    input  logic [NUM_ASR*DW-1:0]  stat_i,
    output logic [DW-1:0]          rd_val_o,
    output logic [NUM_ICR*DW-1:0]  icr_o
);

    localparam int            IW      = $clog2(NUM_ICR);
    localparam int            SW      = $clog2(NUM_ASR);
    localparam logic [DW-1:0] ICR_LIM = DW'(NUM_ICR);
    localparam logic [DW-1:0] ASR_LO  = DW'(ASR_BASE);
    localparam logic [DW-1:0] ASR_HI  = DW'(ASR_BASE + NUM_ASR);

    logic [NUM_ICR-1:0][DW-1:0] icr_d, icr_q;
    logic                       in_icr, in_asr, rd_en, st_en;
    logic [DW-1:0]              asr_off;
    logic [IW-1:0]              icr_idx;
    logic [SW-1:0]              asr_idx;

    always_comb begin
        in_icr  = (off_i < ICR_LIM);
        in_asr  = (off_i >= ASR_LO) && (off_i < ASR_HI);
        asr_off = off_i - ASR_LO;
        icr_idx = off_i[IW-1:0];
        asr_idx = asr_off[SW-1:0];
        rd_en   = icr_q[0][RD_BIT];
        st_en   = icr_q[0][ST_BIT];

        icr_d = icr_q;
        if (we_i && in_icr) begin
            icr_d[icr_idx] = wdata_i;
        end

        if (st_en && in_asr) begin
            rd_val_o = stat_i[asr_idx*DW +: DW];
        end else if (!rd_en) begin
            rd_val_o = off_i;
        end else if (in_icr) begin
            rd_val_o = icr_q[icr_idx];
        end else begin
            rd_val_o = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icr_q <= '0;
        end else begin
            icr_q <= icr_d;
        end
    end

    for (genvar g = 0; g < NUM_ICR; g++) begin : g_flat
        assign icr_o[g*DW +: DW] = icr_q[g];
    end

    // R4: a write in range lands in the addressed byte
    p_icr_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && in_icr) |=> (icr_q[$past(icr_idx)] == $past(wdata_i)));

    // R8: writes aimed at status offsets leave the bank untouched
    p_status_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && in_asr) |=> $stable(icr_q));

endmodule

// File: rtl/uart_idx_rdmux.sv
module uart_idx_rdmux
    import uart_idx_pkg::*;
#(
    parameter int DW = 8
) (
    input  reg_sel_e      sel_i,
    input  logic [DW-1:0] lcr_i,
    input  logic [DW-1:0] spr_i,
    input  logic [DW-1:0] enh_i,
    input  logic [DW-1:0] idx_i,
    output logic [DW-1:0] rd_o
);

    always_comb begin
        unique case (sel_i)
            SEL_LCR: rd_o = lcr_i;
            SEL_SPR: rd_o = spr_i;
            SEL_ENH: rd_o = enh_i;
            SEL_IDX: rd_o = idx_i;
            default: rd_o = '0;
        endcase
    end

endmodule

// File: rtl/uart_idx_regs.sv
module uart_idx_regs
    import uart_idx_pkg::*;
#(
    parameter int            AW       = 3,
    parameter int            DW       = 8,
    parameter int            NUM_ICR  = 16,
    parameter int            NUM_ASR  = 4,
    parameter int            ASR_BASE = 16,
    parameter int            RD_BIT   = 6,
    parameter int            ST_BIT   = 7,
    parameter logic [AW-1:0] A_LCR    = 3'd3,
    parameter logic [AW-1:0] A_IDX    = 3'd5,
    parameter logic [AW-1:0] A_SPR    = 3'd7,
    parameter logic [DW-1:0] KEY      = 8'hBF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [DW-1:0]         wdata_i,
    input  logic [NUM_ASR*DW-1:0] stat_i,
    output logic [DW-1:0]         rdata_o,
    output logic [DW-1:0]         lcr_o,
    output logic [NUM_ICR*DW-1:0] icr_o
);

    localparam int NUM_ENH = 2 ** AW;

    typedef struct packed {
        logic [DW-1:0]              lcr;
        logic [DW-1:0]              spr;
        logic [NUM_ENH-1:0][DW-1:0] enh;
        logic [DW-1:0]              rdata;
    } state_t;

    state_t        st_d, st_q;
    reg_sel_e      sel;
    logic [DW-1:0] idx_val, rd_next, enh_val;
    logic          idx_we;

    uart_idx_decode #(
        .AW(AW), .DW(DW), .A_LCR(A_LCR), .A_IDX(A_IDX), .A_SPR(A_SPR), .KEY(KEY)
    ) u_decode (
        .addr_i (addr_i),
        .lcr_i  (st_q.lcr),
        .sel_o  (sel)
    );

    assign idx_we  = wr_i && (sel == SEL_IDX);
    assign enh_val = st_q.enh[addr_i];

    uart_idx_bank #(
        .DW(DW), .NUM_ICR(NUM_ICR), .NUM_ASR(NUM_ASR), .ASR_BASE(ASR_BASE),
        .RD_BIT(RD_BIT), .ST_BIT(ST_BIT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (idx_we),
        .off_i    (st_q.spr),
        .wdata_i  (wdata_i),
        .stat_i   (stat_i),
        .rd_val_o (idx_val),
        .icr_o    (icr_o)
    );

    uart_idx_rdmux #(.DW(DW)) u_rdmux (
        .sel_i (sel),
        .lcr_i (st_q.lcr),
        .spr_i (st_q.spr),
        .enh_i (enh_val),
        .idx_i (idx_val),
        .rd_o  (rd_next)
    );

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            unique case (sel)
                SEL_LCR: st_d.lcr = wdata_i;
                SEL_SPR: st_d.spr = wdata_i;
                SEL_ENH: st_d.enh[addr_i] = wdata_i;
                default: ;
            endcase
        end
        if (rd_i) begin
            st_d.rdata = rd_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign lcr_o   = st_q.lcr;

    // R2: the line control location always takes the written byte
    p_lcr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_LCR) |=> (lcr_o == $past(wdata_i)));

    // R5: index writes at out-of-range offsets leave the bank alone
    p_idx_oob_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_IDX && lcr_o != KEY && st_q.spr >= DW'(NUM_ICR))
        |=> $stable(icr_o));

    // R9: enhanced-mode writes never reach scratchpad or indexed bank
    p_enh_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && lcr_o == KEY && addr_i != A_LCR)
        |=> ($stable(st_q.spr) && $stable(icr_o)));

    // R11: read data holds without a read strobe
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: tb/uart_idx_regs_tb.sv
module uart_idx_regs_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   addr_i = '0;
    logic         wr_i = 1'b0;
    logic         rd_i = 1'b0;
    logic [7:0]   wdata_i = '0;
    logic [31:0]  stat_i = 32'hA1B2C3D4;
    logic [7:0]   rdata_o, lcr_o;
    logic [127:0] icr_o;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          done = 1'b0;

    logic [7:0] m_lcr, m_spr;
    logic [7:0] m_icr [16];
    logic [7:0] m_enh [8];

    always #5 clk = ~clk;

    uart_idx_regs u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
        .wdata_i(wdata_i), .stat_i(stat_i), .rdata_o(rdata_o), .lcr_o(lcr_o),
        .icr_o(icr_o)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(logic [2:0] a);
        logic [7:0] c;
        c = m_icr[0];
        if (a == 3'd3) return m_lcr;
        if (m_lcr == 8'hBF) return m_enh[a];
        if (a == 3'd7) return m_spr;
        if (a == 3'd5) begin
            if (c[7] && m_spr >= 8'h10 && m_spr < 8'h14)
                return stat_i[m_spr[1:0]*8 +: 8];
            if (!c[6]) return m_spr;
            if (m_spr < 8'h10) return m_icr[m_spr[3:0]];
            return 8'h00;
        end
        return 8'h00;
    endfunction

    function automatic string read_tag(logic [2:0] a);
        if (a == 3'd3) return "R2";
        if (m_lcr == 8'hBF) return "R9";
        if (a == 3'd7) return "R3";
        if (a == 3'd5) begin
            if (m_icr[0][7] && m_spr >= 8'h10 && m_spr < 8'h14) return "R8";
            if (!m_icr[0][6]) return "R6";
            return "R7";
        end
        return "R10";
    endfunction

    function automatic void model_write(logic [2:0] a, logic [7:0] d);
        if (a == 3'd3) m_lcr = d;
        else if (m_lcr == 8'hBF) m_enh[a] = d;
        else if (a == 3'd7) m_spr = d;
        else if (a == 3'd5 && m_spr < 8'h10) m_icr[m_spr[3:0]] = d;
    endfunction

    task automatic do_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        model_write(a, d);
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic do_read(logic [2:0] a);
        logic [7:0] e;
        string      t;
        @(negedge clk);
        addr_i = a; rd_i = 1'b1;
        e = model_read(a);
        t = read_tag(a);
        @(negedge clk);
        rd_i = 1'b0;
        check(t, rdata_o, e);
    endtask

    task automatic check_bank(string tag);
        for (int i = 0; i < 16; i++) check(tag, icr_o[i*8 +: 8], m_icr[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        logic [7:0]  held;
        r = $urandom(32'd20240611);
        m_lcr = '0; m_spr = '0;
        for (int i = 0; i < 16; i++) m_icr[i] = '0;
        for (int i = 0; i < 8; i++) m_enh[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", rdata_o, 8'h00);
        check("R1", lcr_o, 8'h00);
        check_bank("R1");

        // R3 scratchpad, R6 index read with read-enable clear
        do_write(3'd7, 8'h5A);
        do_read(3'd7);
        do_read(3'd5);
        // R4 indexed write
        do_write(3'd7, 8'h02);
        do_write(3'd5, 8'h33);
        check("R4", icr_o[2*8 +: 8], 8'h33);
        do_read(3'd5);
        // R7 read enable
        do_write(3'd7, 8'h00);
        do_write(3'd5, 8'h40);
        do_write(3'd7, 8'h02);
        do_read(3'd5);
        do_write(3'd7, 8'h15);
        do_read(3'd5);
        // R5 / R8 writes at high offsets ignored, status hidden while disabled
        do_write(3'd7, 8'h11);
        do_write(3'd5, 8'hEE);
        check_bank("R5");
        do_read(3'd5);
        do_write(3'd7, 8'h30);
        do_write(3'd5, 8'hEE);
        check_bank("R5");
        // R8 status enable
        do_write(3'd7, 8'h00);
        do_write(3'd5, 8'hC0);
        do_write(3'd7, 8'h11);
        do_read(3'd5);
        check("R8", rdata_o, 8'hC3);
        do_write(3'd7, 8'h00);
        do_write(3'd5, 8'h80);
        do_write(3'd7, 8'h12);
        do_read(3'd5);
        check("R8", rdata_o, 8'hB2);
        do_write(3'd7, 8'h05);
        do_read(3'd5);
        // R2 / R9 enhanced mode
        do_write(3'd3, 8'hBF);
        do_read(3'd3);
        do_write(3'd7, 8'h99);
        do_write(3'd5, 8'h77);
        do_read(3'd7);
        do_read(3'd5);
        check_bank("R9");
        do_write(3'd3, 8'h03);
        do_read(3'd7);
        check("R9", rdata_o, 8'h05);
        // R10 unused addresses in normal mode
        do_write(3'd1, 8'h44);
        do_read(3'd1);
        do_read(3'd7);
        // R11 hold
        held = rdata_o;
        repeat (4) @(negedge clk);
        check("R11", rdata_o, held);

        // random phase
        for (int k = 0; k < 600; k++) begin
            int unsigned op;
            logic [2:0]  a;
            logic [7:0]  d;
            op = $urandom_range(0, 99);
            a  = 3'($urandom_range(0, 7));
            d  = 8'($urandom);
            if (op < 8) begin
                do_write(3'd3, ($urandom_range(0, 3) == 0) ? 8'hBF : d);
            end else if (op < 30) begin
                do_write(3'd7, ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 3))
                                                           : 8'($urandom_range(0, 23)));
            end else if (op < 45) begin
                do_write(3'd5, d);
            end else if (op < 55) begin
                do_write(a, d);
            end else if (op < 60) begin
                @(negedge clk);
                stat_i = $urandom;
            end else if (op < 85) begin
                do_read(3'd5);
            end else if (op < 95) begin
                do_read(a);
            end else begin
                check_bank("R4");
                check("R2", lcr_o, m_lcr);
            end
        end
        do_write(3'd3, 8'h00);
        do_read(3'd7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule